// File: doc/BRIEF.md
# Dual-Frame Positive/Negative Sequence Separator

This block splits a three-phase voltage, given as its alpha/beta pair, into positive-sequence and negative-sequence parts. The vector is turned into two synchronous frames that rotate in opposite directions, one at +θ and one at −θ, where θ comes from an external phase estimate. In each frame, the opposite sequence shows up as a ripple at twice the line frequency. A cross-feedback cell cancels that ripple: it takes the filtered value of the other sequence, turns it through 2θ, and subtracts it. A first-order low-pass filter then smooths each of the four frame signals.

The four filtered values are the d and q parts of each sequence, in that sequence's own frame. Once the loop has settled they are flat, with no ripple. Sine and cosine come from an internal table of 64 steps per turn, built from one quarter wave. Each input sample is marked by a one-cycle strobe. The four results are updated and flagged two clock edges later. The filter coefficient is a fixed parameter, computed beforehand for a cut-off near ω/√2.

Top module: `dualSeqDecoupler`

## Requirements
- R1: While reset is low, and after it until the first result, `outValid` is 0 and all four outputs read 0.
- R2: A sample is taken on each rising edge where `sampleValid` is 1. For each taken sample, `outValid` is 1 for exactly one cycle, which starts at the second rising edge after the sampling edge. `outValid` never pulses otherwise. Samples may arrive on consecutive cycles.
- R3: The angle is the top 6 bits of `phaseIn`. Index k stands for k/64 of a turn: index 0 is 0 and index 16 is a quarter turn, counterclockwise. The lower bits of `phaseIn` have no effect. Sine and cosine are signed values in which 16384 stands for 1.0, and sin²+cos² lies within 2·16384+1 of 16384².
- R4: The positive frame computes d = (α·cos + β·sin)>>>14 and q = (β·cos − α·sin)>>>14. The negative frame computes d = (α·cos − β·sin)>>>14 and q = (α·sin + β·cos)>>>14. Each filter updates as state += (x − state)·A/65536, where A = `AlphaQ16`. With all filters at zero, as after reset, a sample gives outputs of floor(x·A/65536).
- R5: For a pure positive sequence of amplitude P (α = P·cos θ, β = P·sin θ), after settling: `udPos` is within 60 of P, and `uqPos`, `udNeg` and `uqNeg` are each within 60 of 0.
- R6: For a pure negative sequence of amplitude N (α = N·cos θ, β = −N·sin θ), after settling: `udNeg` is within 60 of N, and `uqNeg`, `udPos` and `uqPos` are each within 60 of 0.
- R7: With both sequences present, every output over a full turn of θ after settling stays within 60 of its sequence's value, so no ripple at twice the line frequency is left.
- R8: A positive sequence leading the frame angle by φ settles to `udPos` = P·cos φ and `uqPos` = P·sin φ, within 60.
- R9: Cycles without `sampleValid` leave all four outputs unchanged, whatever `alphaIn`, `betaIn` and `phaseIn` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Marks a new input sample |
| alphaIn | input | DataW | Alpha part of the voltage vector, signed |
| betaIn | input | DataW | Beta part of the voltage vector, signed |
| phaseIn | input | PhaseW | Estimated phase angle word; the top 6 bits are used |
| outValid | output | 1 | One-cycle flag that new results are ready |
| udPos | output | DataW+2 | Positive-sequence d value, signed |
| uqPos | output | DataW+2 | Positive-sequence q value, signed |
| udNeg | output | DataW+2 | Negative-sequence d value, signed |
| uqNeg | output | DataW+2 | Negative-sequence q value, signed |

## Verification
The decoupling loop feeds each sequence's filtered value back into the other frame. As a result, a wrong sign, a wrong 2θ index or a swapped table quadrant does not stay contained. It shows up as ripple or as a steady offset on all four outputs, and within a few hundred samples it exceeds the 60-count window in the settled checks. An error in the rotation or in the filter step is caught exactly on the very first result after reset, where all feedback terms are still zero. Faults in the pipeline strobes show up in the same cycle: either as a missing or extra `outValid` pulse, or as outputs that move during idle cycles.

// File: rtl/seqDecPkg.sv
package seqDecPkg;
  localparam int IdxW = 6;
  localparam int TrigW = 16;
  localparam int TrigFrac = 14;
  localparam int TrigOne = 16384;
  localparam int NumCh = 4;

  typedef struct packed {
    logic loadRot;
    logic updFilt;
  } seqStrobeT;
endpackage

// File: rtl/seqDecTrig.sv
module seqDecTrig
  import seqDecPkg::*;
(
  input  logic [IdxW-1:0]         idx,
  output logic signed [TrigW-1:0] sinV,
  output logic signed [TrigW-1:0] cosV
);
  function automatic logic signed [TrigW-1:0] quarterVal(input logic [4:0] k);
    case (k)
      5'd0:  quarterVal = 16'sd0;
      5'd1:  quarterVal = 16'sd1606;
      5'd2:  quarterVal = 16'sd3196;
      5'd3:  quarterVal = 16'sd4756;
      5'd4:  quarterVal = 16'sd6270;
      5'd5:  quarterVal = 16'sd7723;
      5'd6:  quarterVal = 16'sd9102;
      5'd7:  quarterVal = 16'sd10394;
      5'd8:  quarterVal = 16'sd11585;
      5'd9:  quarterVal = 16'sd12665;
      5'd10: quarterVal = 16'sd13623;
      5'd11: quarterVal = 16'sd14449;
      5'd12: quarterVal = 16'sd15137;
      5'd13: quarterVal = 16'sd15679;
      5'd14: quarterVal = 16'sd16069;
      5'd15: quarterVal = 16'sd16305;
      default: quarterVal = 16'sd16384;
    endcase
  endfunction

  function automatic logic signed [TrigW-1:0] sinOf(input logic [IdxW-1:0] i);
    logic [4:0] k;
    logic [4:0] mirror;
    k = {1'b0, i[3:0]};
    mirror = 5'd16 - k;
    case (i[5:4])
      2'd0: sinOf = quarterVal(k);
      2'd1: sinOf = quarterVal(mirror);
      2'd2: sinOf = -quarterVal(k);
      default: sinOf = -quarterVal(mirror);
    endcase
  endfunction

  always_comb begin
    sinV = sinOf(idx);
    cosV = sinOf(idx + 6'd16);
  end
endmodule

// File: rtl/seqDecLpf.sv
module seqDecLpf #(
  parameter int InW = 19,
  parameter int OutW = 18,
  parameter int AlphaQ16 = 1424,
  parameter int FracBits = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   en,
  input  logic signed [InW-1:0]  xIn,
  output logic signed [OutW-1:0] yOut
);
  localparam int StW = InW + FracBits;
  localparam int CoefW = 18;
  localparam int MulW = StW + 1 + CoefW;

  logic signed [StW-1:0]   state;
  logic signed [StW-1:0]   xScaled;
  logic signed [StW:0]     diff;
  logic signed [CoefW-1:0] coef;
  logic signed [MulW-1:0]  prod;
  logic signed [StW-1:0]   step;

  always_comb begin
    xScaled = {xIn, {FracBits{1'b0}}};
    diff = (StW+1)'(xScaled) - (StW+1)'(state);
    coef = CoefW'(AlphaQ16);
    prod = MulW'(diff) * MulW'(coef);
    step = StW'(prod >>> 16);
    yOut = OutW'(state >>> FracBits);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= '0;
    else if (en) state <= state + step;
  end
endmodule

// File: rtl/seqDecCtrl.sv
module seqDecCtrl
  import seqDecPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleValid,
  output seqStrobeT strobe,
  output logic      outValid
);
  logic updR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updR <= 1'b0;
      outValid <= 1'b0;
    end else begin
      updR <= sampleValid;
      outValid <= updR;
    end
  end

  always_comb begin
    strobe.loadRot = sampleValid;
    strobe.updFilt = updR;
  end

  // R2: every flag traces back to a sample two edges earlier
  assert_valid_after_sample_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(sampleValid, 2));
  // R2: every sample yields its flag
  assert_sample_gives_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> ##1 outValid);
endmodule

// File: rtl/seqDecDatapath.sv
module seqDecDatapath
  import seqDecPkg::*;
#(
  parameter int DataW = 16,
  parameter int PhaseW = 16,
  parameter int AlphaQ16 = 1424,
  parameter int FracBits = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobeT                strobe,
  input  logic signed [DataW-1:0]  alphaIn,
  input  logic signed [DataW-1:0]  betaIn,
  input  logic [PhaseW-1:0]        phaseIn,
  output logic signed [DataW+1:0]  udPos,
  output logic signed [DataW+1:0]  uqPos,
  output logic signed [DataW+1:0]  udNeg,
  output logic signed [DataW+1:0]  uqNeg
);
  localparam int RotW = DataW + 2;
  localparam int OutW = DataW + 2;
  localparam int XW = DataW + 3;
  localparam int ProdW = DataW + TrigW;
  localparam int SumW = ProdW + 1;
  localparam int TProdW = OutW + TrigW;
  localparam int TSumW = TProdW + 1;

  // stage A: rotation into both frames
  logic [IdxW-1:0] idxNow;
  logic unusedPhaseBits;
  logic signed [TrigW-1:0] sinTh, cosTh;
  logic signed [ProdW-1:0] pAc, pAs, pBc, pBs;
  logic signed [SumW-1:0] sumDp, sumQp, sumDn, sumQn;
  logic signed [RotW-1:0] dPosR, qPosR, dNegR, qNegR;
  logic [IdxW-1:0] idxR;

  assign idxNow = phaseIn[PhaseW-1 -: IdxW];
  assign unusedPhaseBits = ^phaseIn[PhaseW-IdxW-1:0];

  seqDecTrig u_trigTheta (.idx(idxNow), .sinV(sinTh), .cosV(cosTh));

  always_comb begin
    pAc = ProdW'(alphaIn) * ProdW'(cosTh);
    pAs = ProdW'(alphaIn) * ProdW'(sinTh);
    pBc = ProdW'(betaIn) * ProdW'(cosTh);
    pBs = ProdW'(betaIn) * ProdW'(sinTh);
    sumDp = SumW'(pAc) + SumW'(pBs);
    sumQp = SumW'(pBc) - SumW'(pAs);
    sumDn = SumW'(pAc) - SumW'(pBs);
    sumQn = SumW'(pAs) + SumW'(pBc);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dPosR <= '0; qPosR <= '0; dNegR <= '0; qNegR <= '0; idxR <= '0;
    end else if (strobe.loadRot) begin
      dPosR <= RotW'(sumDp >>> TrigFrac);
      qPosR <= RotW'(sumQp >>> TrigFrac);
      dNegR <= RotW'(sumDn >>> TrigFrac);
      qNegR <= RotW'(sumQn >>> TrigFrac);
      idxR <= idxNow;
    end
  end

  // stage B: cross decoupling through 2θ, then filtering
  logic [IdxW-1:0] idxTwo;
  logic signed [TrigW-1:0] sinTwo, cosTwo;
  logic signed [OutW-1:0] fVec [NumCh];
  logic signed [XW-1:0] xVec [NumCh];
  logic signed [TSumW-1:0] tDp, tQp, tDn, tQn;

  assign idxTwo = idxR + idxR;

  seqDecTrig u_trigTwo (.idx(idxTwo), .sinV(sinTwo), .cosV(cosTwo));

  function automatic logic signed [TSumW-1:0] mulT(input logic signed [OutW-1:0] v,
                                                   input logic signed [TrigW-1:0] t);
    mulT = TSumW'(TProdW'(v) * TProdW'(t));
  endfunction

  always_comb begin
    // negative sequence seen in the positive frame
    tDp = mulT(fVec[2], cosTwo) + mulT(fVec[3], sinTwo);
    tQp = mulT(fVec[3], cosTwo) - mulT(fVec[2], sinTwo);
    // positive sequence seen in the negative frame
    tDn = mulT(fVec[0], cosTwo) - mulT(fVec[1], sinTwo);
    tQn = mulT(fVec[1], cosTwo) + mulT(fVec[0], sinTwo);
    xVec[0] = XW'(dPosR) - XW'(tDp >>> TrigFrac);
    xVec[1] = XW'(qPosR) - XW'(tQp >>> TrigFrac);
    xVec[2] = XW'(dNegR) - XW'(tDn >>> TrigFrac);
    xVec[3] = XW'(qNegR) - XW'(tQn >>> TrigFrac);
  end

  for (genvar ch = 0; ch < NumCh; ch++) begin : g_filt
    seqDecLpf #(
      .InW(XW), .OutW(OutW), .AlphaQ16(AlphaQ16), .FracBits(FracBits)
    ) u_lpf (
      .clk(clk), .rstN(rstN), .en(strobe.updFilt),
      .xIn(xVec[ch]), .yOut(fVec[ch])
    );
  end

  assign udPos = fVec[0];
  assign uqPos = fVec[1];
  assign udNeg = fVec[2];
  assign uqNeg = fVec[3];

  // R9: filters move only on an update strobe
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.updFilt |=> $stable({fVec[0], fVec[1], fVec[2], fVec[3]}));

  int magTh;
  assign magTh = int'(sinTh) * int'(sinTh) + int'(cosTh) * int'(cosTh);
  // R3: table entries lie on the unit circle
  assert_unit_circle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (magTh >= TrigOne * TrigOne - 2 * TrigOne - 1) && (magTh <= TrigOne * TrigOne + 2 * TrigOne + 1));
endmodule

// File: rtl/dualSeqDecoupler.sv
module dualSeqDecoupler
  import seqDecPkg::*;
#(
  parameter int DataW = 16,
  parameter int PhaseW = 16,
  parameter int AlphaQ16 = 1424,
  parameter int FracBits = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleValid,
  input  logic signed [DataW-1:0] alphaIn,
  input  logic signed [DataW-1:0] betaIn,
  input  logic [PhaseW-1:0]       phaseIn,
  output logic                    outValid,
  output logic signed [DataW+1:0] udPos,
  output logic signed [DataW+1:0] uqPos,
  output logic signed [DataW+1:0] udNeg,
  output logic signed [DataW+1:0] uqNeg
);
  seqStrobeT strobe;

  seqDecCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .strobe(strobe), .outValid(outValid)
  );

  seqDecDatapath #(
    .DataW(DataW), .PhaseW(PhaseW), .AlphaQ16(AlphaQ16), .FracBits(FracBits)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .alphaIn(alphaIn), .betaIn(betaIn), .phaseIn(phaseIn),
    .udPos(udPos), .uqPos(uqPos), .udNeg(udNeg), .uqNeg(uqNeg)
  );
endmodule

// File: tb/test_dualSeqDecoupler.sv
`timescale 1ns/1ps
module test_dualSeqDecoupler;
  localparam int DataW = 16;
  localparam int PhaseW = 16;
  localparam int Alpha = 1424;
  localparam real TwoPi = 6.283185307179586;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [DataW-1:0] alphaIn = '0;
  logic signed [DataW-1:0] betaIn = '0;
  logic [PhaseW-1:0] phaseIn = '0;
  logic outValid;
  logic signed [DataW+1:0] udPos, uqPos, udNeg, uqNeg;

  always #10 clk = ~clk;

  dualSeqDecoupler #(.DataW(DataW), .PhaseW(PhaseW), .AlphaQ16(Alpha)) i_dualSeqDecoupler (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .alphaIn(alphaIn), .betaIn(betaIn), .phaseIn(phaseIn),
    .outValid(outValid), .udPos(udPos), .uqPos(uqPos), .udNeg(udNeg), .uqNeg(uqNeg)
  );

  typedef struct {
    bit    chk;
    int    eDp, eQp, eDn, eQn;
    int    tol;
    string tag;
  } expT;

  expT sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic checkVal(input string tag, input string name, input int act, input int exp, input int tol);
    int d;
    checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d tol=%0d", tag, name, act, exp, tol);
    end
  endtask

  // monitor: pop one expected item per result flag
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (sb.size() == 0) begin
        checkVal("R2", "unexpected outValid", 1, 0, 0);
      end else begin
        expT it;
        it = sb.pop_front();
        if (it.chk) begin
          checkVal(it.tag, "udPos", int'(udPos), it.eDp, it.tol);
          checkVal(it.tag, "uqPos", int'(uqPos), it.eQp, it.tol);
          checkVal(it.tag, "udNeg", int'(udNeg), it.eDn, it.tol);
          checkVal(it.tag, "uqNeg", int'(uqNeg), it.eQn, it.tol);
        end
      end
    end
  end

  function automatic int firstOut(input int x);
    longint p;
    p = longint'(x) * Alpha;
    return int'(p >>> 16);
  endfunction

  task automatic doReset();
    sampleValid = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    checkVal("R1", "outValid in reset", int'(outValid), 0, 0);
    checkVal("R1", "udPos in reset", int'(udPos), 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1", "outValid after reset", int'(outValid), 0, 0);
    checkVal("R1", "outputs after reset", int'(uqPos) | int'(udNeg) | int'(uqNeg), 0, 0);
  endtask

  // one sample after reset, with exact expected values and latency
  task automatic firstSample(input int a, input int b, input int ph, input int dp, input int qp,
                             input int dn, input int qn, input string tag);
    expT it;
    doReset();
    it.chk = 1; it.tol = 0; it.tag = tag;
    it.eDp = firstOut(dp); it.eQp = firstOut(qp);
    it.eDn = firstOut(dn); it.eQn = firstOut(qn);
    alphaIn = DataW'(a); betaIn = DataW'(b); phaseIn = PhaseW'(ph);
    sampleValid = 1'b1;
    sb.push_back(it);
    @(negedge clk);
    sampleValid = 1'b0;
    checkVal("R2", "outValid one edge after sample", int'(outValid), 0, 0);
    @(negedge clk);
    checkVal("R2", "outValid two edges after sample", int'(outValid), 1, 0);
    @(negedge clk);
    checkVal("R2", "outValid single pulse", int'(outValid), 0, 0);
  endtask

  // stream of samples at one table step per sample
  task automatic runSeq(input real pAmp, input int phiIdx, input real nAmp, input int nSamp,
                        input string tag);
    real phi;
    phi = TwoPi * phiIdx / 64.0;
    doReset();
    for (int n = 0; n < nSamp; n++) begin
      expT it;
      int idx;
      real th;
      idx = n % 64;
      th = TwoPi * idx / 64.0;
      alphaIn = DataW'(int'(pAmp * $cos(th + phi) + nAmp * $cos(th)));
      betaIn = DataW'(int'(pAmp * $sin(th + phi) - nAmp * $sin(th)));
      phaseIn = PhaseW'((idx << 10) | ((n * 37) & 1023));
      sampleValid = 1'b1;
      it.chk = (n >= nSamp - 64);
      it.tol = 60; it.tag = tag;
      it.eDp = int'(pAmp * $cos(phi)); it.eQp = int'(pAmp * $sin(phi));
      it.eDn = int'(nAmp); it.eQn = 0;
      sb.push_back(it);
      @(negedge clk);
    end
    sampleValid = 1'b0;
    repeat (4) @(negedge clk);
    checkVal("R2", "all results delivered", sb.size(), 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int hDp, hQp, hDn, hQn;
    // R4 with R3 index 0: identity rotation, junk low phase bits
    firstSample(20000, -7000, 16'h0123, 20000, -7000, 20000, -7000, "R4/R3 idx0");
    // R4 with R3 index 16: quarter turn, junk low phase bits
    firstSample(12000, 20000, 16'h4155, 20000, -12000, -20000, 12000, "R4/R3 idx16");
    // R5 positive sequence only
    runSeq(8000.0, 0, 0.0, 1600, "R5");
    // R6 negative sequence only
    runSeq(0.0, 0, 6000.0, 1600, "R6");
    // R8 positive sequence leading by 45 degrees
    runSeq(8000.0, 8, 0.0, 1600, "R8");
    // R7 both sequences, full turn checked for ripple
    runSeq(8000.0, 0, 4000.0, 1600, "R7");
    // R9 idle cycles with moving inputs
    hDp = int'(udPos); hQp = int'(uqPos); hDn = int'(udNeg); hQn = int'(uqNeg);
    for (int i = 0; i < 30; i++) begin
      alphaIn = DataW'($urandom);
      betaIn = DataW'($urandom);
      phaseIn = PhaseW'($urandom);
      @(negedge clk);
    end
    checkVal("R9", "udPos held", int'(udPos), hDp, 0);
    checkVal("R9", "uqPos held", int'(uqPos), hQp, 0);
    checkVal("R9", "udNeg held", int'(udNeg), hDn, 0);
    checkVal("R9", "uqNeg held", int'(uqNeg), hQn, 0);
    checkVal("R9", "no flag while idle", sb.size(), 0, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule